// File: doc/BRIEF.md
# SPI Flash Program/Erase Sequencer

This block sits on the host side of a serial NOR flash. It turns a single program or erase request into the full sequence of SPI command frames the flash needs. A request names its kind (page program, 4 KB, 8 KB or 64 KB sector erase, or whole-device erase), a 24-bit flash address and, for a program, a byte count from 1 to 256. The sequencer works through the request in this order:

1. It sends a write-enable frame.
2. It sends the program or erase frame. Program data is fetched from a local page buffer through a simple combinational read port.
3. It reads the flash status register over and over until the busy bit clears or a poll limit runs out.
4. It returns a one-cycle result: success, program failure, erase failure or timeout.

Chip select goes high between every two frames and stays high for a minimum number of clocks, which is set by a parameter. An internal byte-wide SPI master drives the serial lines. It runs in mode 0, most significant bit first, and its SCK half period is set by a parameter. Requests use a valid/ready handshake, and only one request is in flight at a time.

Top module: `flash_pe_seq`

## Requirements
- R1: `req_ready_o` is high only while the sequencer is idle. A request is taken on a clock edge where `req_valid_i` and `req_ready_o` are both high. While a request is in progress, `req_valid_i` is ignored and starts no frames.
- R2: Each request begins with a frame that holds only the byte 0x06.
- R3: For kind 0 (program), the operation frame is 0x02, then three address bytes with the most significant byte first, then `req_len_m1_i`+1 data bytes. Data byte k is read from buffer address k, in increasing order.
- R4: Kinds 1, 2 and 3 send 0x20, 0x40 and 0xD8 followed by three address bytes, most significant byte first. Kind 4 sends the single byte 0xC7 with no address.
- R5: After the operation frame, the block sends status frames, each made of 0x05 and one dummy byte. The status is the byte returned during the dummy byte. Polling stops at the first status whose bit 0 is 0, so a flash that reports busy N times sees N+1 polls.
- R6: When bit 0 is 0, `done_status_o` is 1 if the request was a program and status bit 6 is set. It is 2 if the request was an erase and status bit 5 is set. Otherwise it is 0. The error bit that belongs to the other kind of request is ignored.
- R7: If MAX_POLLS polls in a row all return bit 0 set, the request ends with `done_status_o` = 3 and no further poll is sent.
- R8: Between any two frames, chip select stays high for at least CS_GAP clocks, and SCK toggles only while chip select is low.
- R9: SPI mode 0 is used. SCK idles low, MOSI changes only while SCK is low, and bits go out most significant first. Each SCK phase lasts CLK_DIV clocks.
- R10: Each accepted request produces exactly one `done_valid_o` pulse, one clock long.
- R11: After reset, `req_ready_o` = 1, `spi_cs_no` = 1, `spi_sck_o` = 0 and `done_valid_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Sequencer idle, able to take a request |
| req_kind_i | input | 3 | 0 program, 1 erase 4 KB, 2 erase 8 KB, 3 erase 64 KB, 4 erase all |
| req_addr_i | input | 24 | Flash byte address |
| req_len_m1_i | input | 8 | Program byte count minus one |
| buf_addr_o | output | 8 | Page buffer read address |
| buf_data_i | input | 8 | Page buffer read data, combinational |
| done_valid_o | output | 1 | One-cycle completion pulse |
| done_status_o | output | 2 | 0 ok, 1 program error, 2 erase error, 3 timeout |
| spi_sck_o | output | 1 | Serial clock |
| spi_cs_no | output | 1 | Chip select, active low |
| spi_mosi_o | output | 1 | Serial data to flash |
| spi_miso_i | input | 1 | Serial data from flash |

## Verification
The completion pulse of one request and the arrival of the next request can fall in the same cycle. Ready rises on the same edge that raises `done_valid_o`. The bench provokes this by holding `req_valid_i` high, with a different request kind, from early in a program sequence through its completion. It then confirms three things: ready stayed low the whole time, the flash stub saw exactly one operation frame before the done pulse, and the held request was taken right after the pulse and ran as a complete second sequence. A bench flash stub decodes every frame and counts polls. It checks write-enable ordering, addresses, data bytes and the spacing between frames against values that the bench computes itself.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  typedef enum logic [2:0] {
    KIND_PROG  = 3'd0,
    KIND_ER4K  = 3'd1,
    KIND_ER8K  = 3'd2,
    KIND_ER64K = 3'd3,
    KIND_ERALL = 3'd4
  } req_kind_e;

  typedef enum logic [1:0] {FR_WREN, FR_OP, FR_POLL} frame_e;
  typedef enum logic [1:0] {ST_IDLE, ST_GAP, ST_FRAME} seq_st_e;

  typedef enum logic [1:0] {
    RES_OK        = 2'd0,
    RES_PROG_ERR  = 2'd1,
    RES_ERASE_ERR = 2'd2,
    RES_TIMEOUT   = 2'd3
  } result_e;

  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_PROG  = 8'h02;
  localparam logic [7:0] OP_ER4K  = 8'h20;
  localparam logic [7:0] OP_ER8K  = 8'h40;
  localparam logic [7:0] OP_ER64K = 8'hD8;
  localparam logic [7:0] OP_ERALL = 8'hC7;
  localparam logic [7:0] OP_RDSR  = 8'h05;

  localparam int unsigned SR_BUSY_BIT = 0;
  localparam int unsigned SR_EERR_BIT = 5;
  localparam int unsigned SR_PERR_BIT = 6;
endpackage

// File: rtl/spi_byte_master.sv
module spi_byte_master #(
  parameter int unsigned CLK_DIV = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [7:0] tx_i,
  output logic       busy_o,
  output logic       done_o,
  output logic [7:0] rx_o,
  output logic       sck_o,
  output logic       mosi_o,
  input  logic       miso_i
);
  localparam int unsigned DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);

  logic [DIV_W-1:0] div_q;
  logic             active_q, sck_q, done_q;
  logic [2:0]       bit_q;
  logic [7:0]       tx_q, rx_q;
  logic             tick;

  assign tick = active_q && (div_q == DIV_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q    <= '0;
      active_q <= 1'b0;
      sck_q    <= 1'b0;
      done_q   <= 1'b0;
      bit_q    <= '0;
      tx_q     <= '0;
      rx_q     <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !active_q) begin
        active_q <= 1'b1;
        tx_q     <= tx_i;
        bit_q    <= '0;
        div_q    <= '0;
        sck_q    <= 1'b0;
      end else if (active_q) begin
        if (tick) begin
          div_q <= '0;
          if (!sck_q) begin
            sck_q <= 1'b1;
            rx_q  <= {rx_q[6:0], miso_i};  // sample on rising edge
          end else begin
            sck_q <= 1'b0;
            if (bit_q == 3'd7) begin
              active_q <= 1'b0;
              done_q   <= 1'b1;
            end else begin
              bit_q <= bit_q + 3'd1;
              tx_q  <= {tx_q[6:0], 1'b0};  // shift on falling edge
            end
          end
        end else begin
          div_q <= div_q + DIV_W'(1);
        end
      end
    end
  end

  assign busy_o = active_q;
  assign done_o = done_q;
  assign rx_o   = rx_q;
  assign sck_o  = sck_q;
  assign mosi_o = tx_q[7];

  AST_MOSI_STABLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_q |-> $stable(mosi_o)) else $error("mosi moved while sck high"); // R9
  AST_START_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !active_q) else $error("byte start while shifting"); // R9
  AST_SCK_PHASE_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && $past(active_q) && sck_q != $past(sck_q)) |-> $past(div_q) == DIV_LAST)
    else $error("sck phase length wrong"); // R9
endmodule

// File: rtl/op_frame_builder.sv
module op_frame_builder
  import flash_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 24
) (
  input  frame_e            frame_i,
  input  req_kind_e         kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        len_m1_i,
  input  logic [8:0]        idx_i,
  input  logic [7:0]        buf_data_i,
  output logic [7:0]        buf_addr_o,
  output logic [7:0]        tx_o,
  output logic [8:0]        last_idx_o
);
  localparam int unsigned ADDR_BYTES = ADDR_W / 8;

  logic [7:0] addr_byte [ADDR_BYTES];
  logic [7:0] op_code;

  // most significant address byte goes first
  for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_abyte
    assign addr_byte[g] = addr_i[ADDR_W-1-8*g -: 8];
  end

  assign buf_addr_o = 8'(idx_i - 9'(ADDR_BYTES + 1));

  always_comb begin
    case (kind_i)
      KIND_PROG:  op_code = OP_PROG;
      KIND_ER4K:  op_code = OP_ER4K;
      KIND_ER8K:  op_code = OP_ER8K;
      KIND_ER64K: op_code = OP_ER64K;
      default:    op_code = OP_ERALL;
    endcase
  end

  always_comb begin
    tx_o       = 8'h00;
    last_idx_o = '0;
    case (frame_i)
      FR_WREN: begin
        tx_o       = OP_WREN;
        last_idx_o = '0;
      end
      FR_POLL: begin
        tx_o       = (idx_i == '0) ? OP_RDSR : 8'h00;
        last_idx_o = 9'd1;
      end
      default: begin
        if (kind_i == KIND_PROG)
          last_idx_o = 9'(ADDR_BYTES) + {1'b0, len_m1_i} + 9'd1;
        else if (op_code == OP_ERALL)
          last_idx_o = '0;
        else
          last_idx_o = 9'(ADDR_BYTES);
        if (idx_i == '0)
          tx_o = op_code;
        else if (idx_i <= 9'(ADDR_BYTES))
          tx_o = addr_byte[idx_i - 9'd1];
        else
          tx_o = buf_data_i;
      end
    endcase
  end
endmodule

// File: rtl/poll_result_eval.sv
module poll_result_eval
  import flash_seq_pkg::*;
(
  input  req_kind_e  kind_i,
  input  logic [7:0] status_i,
  input  logic       last_poll_i,
  output logic       finish_o,
  output result_e    result_o
);
  logic busy;
  assign busy     = status_i[SR_BUSY_BIT];
  assign finish_o = !busy || last_poll_i;

  always_comb begin
    if (busy)
      result_o = RES_TIMEOUT;
    else if (kind_i == KIND_PROG)
      result_o = status_i[SR_PERR_BIT] ? RES_PROG_ERR : RES_OK;
    else
      result_o = status_i[SR_EERR_BIT] ? RES_ERASE_ERR : RES_OK;
  end
endmodule

// File: rtl/flash_pe_seq.sv
module flash_pe_seq
  import flash_seq_pkg::*;
#(
  parameter int unsigned CLK_DIV   = 2,
  parameter int unsigned CS_GAP    = 3,
  parameter int unsigned MAX_POLLS = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  output logic        req_ready_o,
  input  logic [2:0]  req_kind_i,
  input  logic [23:0] req_addr_i,
  input  logic [7:0]  req_len_m1_i,
  output logic [7:0]  buf_addr_o,
  input  logic [7:0]  buf_data_i,
  output logic        done_valid_o,
  output logic [1:0]  done_status_o,
  output logic        spi_sck_o,
  output logic        spi_cs_no,
  output logic        spi_mosi_o,
  input  logic        spi_miso_i
);
  localparam int unsigned GAP_W = $clog2(CS_GAP + 1);
  localparam int unsigned PC_W  = $clog2(MAX_POLLS + 1);
  localparam logic [GAP_W-1:0] GAP_LAST  = GAP_W'(CS_GAP - 1);
  localparam logic [PC_W-1:0]  POLL_LAST = PC_W'(MAX_POLLS - 1);

  seq_st_e          st_q;
  frame_e           frame_q;
  req_kind_e        kind_q;
  logic [23:0]      addr_q;
  logic [7:0]       len_q;
  logic [8:0]       idx_q;
  logic             in_flight_q;
  logic [GAP_W-1:0] gap_q;
  logic [PC_W-1:0]  poll_q;
  logic             cs_n_q, done_q;
  result_e          result_q;

  logic       spi_start, spi_busy, spi_done;
  logic [7:0] spi_tx, spi_rx;
  logic [8:0] last_idx;
  logic       ev_finish;
  result_e    ev_result;

  assign spi_start = (st_q == ST_FRAME) && !in_flight_q && !spi_busy;

  op_frame_builder #(.ADDR_W(24)) u_frame (
    .frame_i    (frame_q),
    .kind_i     (kind_q),
    .addr_i     (addr_q),
    .len_m1_i   (len_q),
    .idx_i      (idx_q),
    .buf_data_i (buf_data_i),
    .buf_addr_o (buf_addr_o),
    .tx_o       (spi_tx),
    .last_idx_o (last_idx)
  );

  poll_result_eval u_eval (
    .kind_i      (kind_q),
    .status_i    (spi_rx),
    .last_poll_i (poll_q == POLL_LAST),
    .finish_o    (ev_finish),
    .result_o    (ev_result)
  );

  spi_byte_master #(.CLK_DIV(CLK_DIV)) u_spi (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (spi_start),
    .tx_i    (spi_tx),
    .busy_o  (spi_busy),
    .done_o  (spi_done),
    .rx_o    (spi_rx),
    .sck_o   (spi_sck_o),
    .mosi_o  (spi_mosi_o),
    .miso_i  (spi_miso_i)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      frame_q     <= FR_WREN;
      kind_q      <= KIND_PROG;
      addr_q      <= '0;
      len_q       <= '0;
      idx_q       <= '0;
      in_flight_q <= 1'b0;
      gap_q       <= '0;
      poll_q      <= '0;
      cs_n_q      <= 1'b1;
      done_q      <= 1'b0;
      result_q    <= RES_OK;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        ST_IDLE: if (req_valid_i) begin
          kind_q  <= req_kind_e'(req_kind_i);
          addr_q  <= req_addr_i;
          len_q   <= req_len_m1_i;
          frame_q <= FR_WREN;
          poll_q  <= '0;
          gap_q   <= '0;
          st_q    <= ST_GAP;
        end
        ST_GAP: begin
          if (gap_q == GAP_LAST) begin
            gap_q  <= '0;
            idx_q  <= '0;
            cs_n_q <= 1'b0;
            st_q   <= ST_FRAME;
          end else begin
            gap_q <= gap_q + GAP_W'(1);
          end
        end
        ST_FRAME: begin
          if (spi_start) in_flight_q <= 1'b1;
          if (spi_done) begin
            in_flight_q <= 1'b0;
            if (idx_q == last_idx) begin
              cs_n_q <= 1'b1;
              st_q   <= ST_GAP;
              case (frame_q)
                FR_WREN: frame_q <= FR_OP;
                FR_OP:   frame_q <= FR_POLL;
                default: begin
                  if (ev_finish) begin
                    st_q     <= ST_IDLE;
                    done_q   <= 1'b1;
                    result_q <= ev_result;
                  end else begin
                    poll_q <= poll_q + PC_W'(1);
                  end
                end
              endcase
            end else begin
              idx_q <= idx_q + 9'd1;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o   = (st_q == ST_IDLE);
  assign spi_cs_no     = cs_n_q;
  assign done_valid_o  = done_q;
  assign done_status_o = result_q;

  // count of clocks chip select has been high, for the gap check only
  logic [GAP_W-1:0] cs_hi_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cs_hi_q <= '0;
    else if (!cs_n_q) cs_hi_q <= '0;
    else if (cs_hi_q != GAP_W'(CS_GAP)) cs_hi_q <= cs_hi_q + GAP_W'(1);
  end

  AST_READY_CS_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> spi_cs_no) else $error("ready while frame open"); // R1
  AST_CS_GAP_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(spi_cs_no) |-> cs_hi_q >= GAP_W'(CS_GAP)) else $error("cs gap short"); // R8
  AST_SPI_IN_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_busy |-> !spi_cs_no) else $error("shifting with cs high"); // R8
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_valid_o |=> !done_valid_o) else $error("done longer than one cycle"); // R10
  AST_POLL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    poll_q < PC_W'(MAX_POLLS)) else $error("poll count overran"); // R7
endmodule

// File: tb/flash_pe_seq_bench.sv
module flash_pe_seq_bench;
  localparam int CLK_DIV   = 2;
  localparam int CS_GAP    = 3;
  localparam int MAX_POLLS = 16;
  localparam int NV        = 8;

  // kind, addr, len-1, busy reads, p_err, e_err, expected result, expected opcode
  localparam logic [2:0]  V_KIND [NV] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd0, 3'd0, 3'd1};
  localparam logic [23:0] V_ADDR [NV] = '{24'h012300, 24'h00A000, 24'h004000, 24'h3F0000,
                                          24'h5A5A5A, 24'h100000, 24'h0000FF, 24'h0FF000};
  localparam logic [7:0]  V_LEN  [NV] = '{8'd3, 8'd0, 8'd0, 8'd0, 8'd0, 8'd255, 8'd0, 8'd0};
  localparam int          V_BUSY [NV] = '{2, 0, 1, 3, 1, 1, 0, 20};
  localparam logic        V_PERR [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0};
  localparam logic        V_EERR [NV] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0};
  localparam logic [1:0]  V_RES  [NV] = '{2'd0, 2'd0, 2'd2, 2'd0, 2'd0, 2'd1, 2'd0, 2'd3};
  localparam logic [7:0]  V_OP   [NV] = '{8'h02, 8'h20, 8'h40, 8'hD8, 8'hC7, 8'h02, 8'h02, 8'h20};

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [2:0] req_kind = '0;
  logic [23:0] req_addr = '0;
  logic [7:0] req_len = '0;
  logic req_ready, done_valid, sck, cs_n, mosi, miso;
  logic [1:0] done_status;
  logic [7:0] buf_addr, buf_data;

  always #10 clk = ~clk;

  function automatic logic [7:0] buf_val(input int i);
    return 8'((i * 37 + 11) ^ (i >> 3));
  endfunction
  assign buf_data = buf_val(int'(buf_addr));

  flash_pe_seq #(.CLK_DIV(CLK_DIV), .CS_GAP(CS_GAP), .MAX_POLLS(MAX_POLLS)) u_flash_pe_seq (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_kind_i(req_kind), .req_addr_i(req_addr), .req_len_m1_i(req_len),
    .buf_addr_o(buf_addr), .buf_data_i(buf_data),
    .done_valid_o(done_valid), .done_status_o(done_status),
    .spi_sck_o(sck), .spi_cs_no(cs_n), .spi_mosi_o(mosi), .spi_miso_i(miso)
  );

  // ---- flash stub ----
  int cfg_busy = 0; logic cfg_perr = 0, cfg_eerr = 0;
  int bitc, byte_n, dcnt, dmis, busy_left = 0;
  logic [7:0] sh, opc, out_sh = 8'h00, last_frame = 8'h00;
  logic [23:0] addr_f;
  logic shift_ok, wel = 1'b0;
  int nops = 0, npolls = 0, op_bytes, op_dcnt, op_dmis;
  logic [7:0] op_code, op_prev; logic [23:0] op_addr; logic op_wel;
  int hi_cnt = 1000, gap_viol = 0;

  assign miso = out_sh[7];

  function automatic logic [7:0] status_now();
    logic wip;
    wip = busy_left > 0;
    return {1'b0, cfg_perr && !wip, cfg_eerr && !wip, 3'b000, wel, wip};
  endfunction

  always @(negedge cs_n) begin
    bitc = 0; byte_n = 0; dcnt = 0; dmis = 0; addr_f = '0;
    opc = 8'hFF; out_sh = 8'h00; shift_ok = 1'b0;
  end

  always @(posedge sck) if (!cs_n) begin
    sh = {sh[6:0], mosi};
    bitc++;
    if (bitc > 8) shift_ok = 1'b1;
    if (bitc % 8 == 0) begin
      if (byte_n == 0) begin
        opc = sh;
        if (sh == 8'h05) out_sh = status_now();
      end else if (byte_n <= 3) addr_f = {addr_f[15:0], sh};
      else if (opc == 8'h02) begin
        if (sh != buf_val(byte_n - 4)) dmis++;
        dcnt++;
      end
      byte_n++;
    end
  end

  always @(negedge sck) if (!cs_n && shift_ok) out_sh = {out_sh[6:0], 1'b0};

  always @(posedge cs_n) begin
    case (opc)
      8'h06: wel = 1'b1;
      8'h05: begin npolls++; if (busy_left > 0) busy_left--; end
      8'h02, 8'h20, 8'h40, 8'hD8, 8'hC7: begin
        nops++; op_code = opc; op_prev = last_frame; op_wel = wel; wel = 1'b0;
        op_addr = addr_f; op_bytes = byte_n; op_dcnt = dcnt; op_dmis = dmis;
        busy_left = cfg_busy;
      end
      default: ;
    endcase
    last_frame = opc;
  end

  always @(negedge clk) begin
    if (cs_n) hi_cnt++;
    else begin
      if (hi_cnt > 0 && hi_cnt < CS_GAP) gap_viol++;
      hi_cnt = 0;
    end
  end

  // ---- checking ----
  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic wait_done(output logic [1:0] st);
    int t;
    t = 0;
    @(negedge clk);
    while (!done_valid && t < 60000) begin @(negedge clk); t++; end
    st = done_status;
    if (!done_valid) begin
      chk(1'b0, "R10", "watchdog waiting for done", 0, 1);
      finish_run();
    end
    @(negedge clk);
    chk(!done_valid, "R10", "done pulse width", longint'(done_valid), 0);
  endtask

  task automatic issue(input logic [2:0] k, input logic [23:0] a, input logic [7:0] l);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_kind = k; req_addr = a; req_len = l; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    #(20ns * 200000);
    chk(1'b0, "R10", "global watchdog", 0, 1);
    finish_run();
  end

  initial begin
    logic [1:0] st;
    int exp_polls, exp_bytes, p0, ready_hi;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(req_ready == 1'b1, "R11", "ready in reset", longint'(req_ready), 1);
    chk(cs_n == 1'b1, "R11", "cs in reset", longint'(cs_n), 1);
    chk(sck == 1'b0, "R11", "sck in reset", longint'(sck), 0);
    chk(done_valid == 1'b0, "R11", "done in reset", longint'(done_valid), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(req_ready && cs_n && !sck, "R11", "idle after reset", longint'({req_ready, cs_n, sck}), 3'b110);

    for (int v = 0; v < NV; v++) begin
      cfg_busy = V_BUSY[v]; cfg_perr = V_PERR[v]; cfg_eerr = V_EERR[v];
      nops = 0; p0 = npolls;
      issue(V_KIND[v], V_ADDR[v], V_LEN[v]);
      wait_done(st);
      exp_polls = (V_BUSY[v] >= MAX_POLLS) ? MAX_POLLS : V_BUSY[v] + 1;
      exp_bytes = (V_KIND[v] == 3'd0) ? 4 + int'(V_LEN[v]) + 1 : (V_KIND[v] == 3'd4) ? 1 : 4;
      chk(st == V_RES[v], (V_RES[v] == 2'd3) ? "R7" : "R6", $sformatf("result v%0d", v), st, V_RES[v]);
      chk(nops == 1, "R1", $sformatf("op frames v%0d", v), nops, 1);
      chk(op_code == V_OP[v], (V_KIND[v] == 3'd0) ? "R3" : "R4", $sformatf("opcode v%0d", v), op_code, V_OP[v]);
      chk(op_prev == 8'h06 && op_wel, "R2", $sformatf("wren before op v%0d", v), op_prev, 8'h06);
      chk(npolls - p0 == exp_polls, (V_RES[v] == 2'd3) ? "R7" : "R5", $sformatf("polls v%0d", v), npolls - p0, exp_polls);
      chk(op_bytes == exp_bytes, "R4", $sformatf("frame bytes v%0d", v), op_bytes, exp_bytes);
      if (V_KIND[v] != 3'd4)
        chk(op_addr == V_ADDR[v], "R4", $sformatf("address v%0d", v), op_addr, V_ADDR[v]);
      if (V_KIND[v] == 3'd0) begin
        chk(op_dcnt == int'(V_LEN[v]) + 1, "R3", $sformatf("data count v%0d", v), op_dcnt, int'(V_LEN[v]) + 1);
        chk(op_dmis == 0, "R3", $sformatf("data order v%0d", v), op_dmis, 0);
      end
      chk(gap_viol == 0, "R8", $sformatf("cs gap v%0d", v), gap_viol, 0);
    end

    // R1: request held through a running program and its done pulse
    cfg_busy = 3; cfg_perr = 0; cfg_eerr = 0; nops = 0; ready_hi = 0;
    issue(3'd0, 24'h00AB00, 8'd7);
    req_kind = 3'd1; req_addr = 24'h077000; req_len = 8'd0; req_valid = 1'b1;
    @(negedge clk);
    while (!done_valid) begin
      if (req_ready) ready_hi++;
      @(negedge clk);
    end
    st = done_status;
    chk(ready_hi == 0, "R1", "ready while busy", ready_hi, 0);
    chk(nops == 1 && op_code == 8'h02, "R1", "held request did not start a frame", nops, 1);
    chk(st == 2'd0, "R6", "first of back-to-back", st, 0);
    chk(req_ready == 1'b1, "R1", "ready with done", longint'(req_ready), 1);
    cfg_busy = 0;
    @(negedge clk);
    req_valid = 1'b0;
    wait_done(st);
    chk(nops == 2 && op_code == 8'h20, "R1", "held request taken after done", op_code, 8'h20);
    chk(op_addr == 24'h077000, "R4", "held request address", op_addr, 24'h077000);
    chk(gap_viol == 0, "R8", "cs gap back-to-back", gap_viol, 0);
    finish_run();
  end
endmodule